// File: doc/BRIEF.md
# MDIO Management Command Master

This block lets an Ethernet MAC reach the management registers of an external PHY. Software writes one 32-bit command word. That word names a PHY address, a PHY register number and an operation. For a write it also carries the 16-bit value to send. The block then runs one clause-22 management frame on a derived management clock and a single data line, which it can drive or release.

The command register can always be read back. A read operation deposits the PHY's 16-bit answer in the upper half of that register and leaves the lower half as it was written. A busy flag in the register shows that a frame is on the wire. While the flag is set, new commands are dropped.

The frame is made of the following fields, sent most significant bit first:
- a preamble of `PREAMBLE_LEN` ones (32 by default);
- the start pattern 01;
- an opcode, 10 for a read and 01 for a write;
- the 5-bit PHY address;
- the 5-bit register number;
- a two-bit turnaround;
- 16 data bits.

Top module: `mdio_cmd_master`

## Requirements
- R1: Bits 15:11 of the command word are the PHY address and bits 10:6 the register number. They appear MSB first in the frame, right after the preamble of ones, the start pattern 01 and the opcode.
- R2: Command bit 1 requests a read (opcode 10) and bit 0 requests a write (opcode 01). When both are set, a read frame is run.
- R3: A write frame drives the line for all of its bits. It sends turnaround 10 and then bits 31:16 of the command word, MSB first.
- R4: A read frame drives the line for the preamble, start, opcode and both addresses, then releases it (output enable low) for the turnaround and the 16 data bits. The data bits sampled from `mdioIn` replace bits 31:16 of the register, and bits 15:0 keep the written value.
- R5: A command with bits 1:0 both zero is stored but starts no frame: busy stays 0 and `mdc` does not toggle.
- R6: `mdc` is low when idle and toggles every `MDC_HALF` system clocks during a frame, so its period is 2*`MDC_HALF` cycles. `mdioOut` changes only when `mdc` falls, and input is sampled when `mdc` rises.
- R7: Register bit 2 reads 1 from the clock after a frame starts until it ends. A command write while busy changes neither the register nor the frame in progress, and starts nothing afterwards.
- R8: After reset the register reads 0, and `mdc`, `mdioOe` and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 32 | Command word |
| cmdRdData | output | 32 | Register readback; bit 2 is busy |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data out |
| mdioOe | output | 1 | Drive enable for the data line |
| mdioIn | input | 1 | Management data in |

## Verification
The hardest case to reach from the ports is the read frame's data phase. Reaching it needs a PHY that answers in step with the block's own divided clock, after the block has let go of the line. The bench follows `mdc` edge by edge as a PHY would. It records every bit and its enable on rising edges, and it drives its answer after each falling edge from the turnaround on. Command writes are also issued in the middle of a running frame and checked against the readback and the frame bits.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic store;       // latch command word into the register
    logic start;       // load the frame shifter
    logic opRead;      // operation chosen for the frame being loaded
    logic shift;       // advance to the next bit (mdc falling)
    logic sample;      // capture mdioIn (mdc rising)
    logic commitRead;  // move captured data into the register upper half
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF     = 2,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic        rdReq,
  input  logic        wrReq,
  output mdioStrobe_t strb,
  output logic        mdc,
  output logic        mdioOe,
  output logic        busy
);
  localparam int FRAME_LEN  = PREAMBLE_LEN + 32;
  localparam int DRIVE_LEN  = PREAMBLE_LEN + 14;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int DIV_W      = $clog2(MDC_HALF + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] DRIVE_END = IDX_W'(DRIVE_LEN);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(MDC_HALF - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             isRead;
  logic             edgeTick;
  logic             lastBit;

  assign edgeTick = busy && (divCnt == DIV_LAST);
  assign lastBit  = (bitIdx == LAST_IDX);

  always_comb begin
    strb.store      = cmdWrEn && !busy;
    strb.start      = cmdWrEn && !busy && (rdReq || wrReq);
    strb.opRead     = rdReq;
    strb.sample     = edgeTick && !mdc;
    strb.shift      = edgeTick && mdc && !lastBit;
    strb.commitRead = edgeTick && mdc && lastBit && isRead;
  end

  assign mdioOe = busy && (!isRead || (bitIdx < DRIVE_END));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      isRead <= 1'b0;
    end else if (!busy) begin
      if (strb.start) begin
        busy   <= 1'b1;
        isRead <= rdReq;
        divCnt <= '0;
        bitIdx <= '0;
        mdc    <= 1'b0;
      end
    end else if (edgeTick) begin
      divCnt <= '0;
      mdc    <= !mdc;
      if (mdc) begin
        if (lastBit) busy <= 1'b0;
        else         bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R6: clock stays low outside a frame
  p_mdc_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R5: a command without an operation never starts a frame
  p_noop_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !busy && !rdReq && !wrReq) |=> !busy);
  // R7: an accepted operation raises busy on the next clock
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && !busy && (rdReq || wrReq)) |=> busy);
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic [31:0] cmdWrData,
  input  logic        mdioIn,
  input  logic        busy,
  output logic        mdioOut,
  output logic [31:0] regValue
);
  localparam int FRAME_LEN = PREAMBLE_LEN + 32;

  logic [31:0]          cmdReg;
  logic [FRAME_LEN-1:0] frameSr;
  logic [15:0]          rdSr;
  logic [31:0]          frameBody;

  always_comb begin
    frameBody = {2'b01, (strb.opRead ? 2'b10 : 2'b01),
                 cmdWrData[15:11], cmdWrData[10:6], 2'b10,
                 (strb.opRead ? 16'h0000 : cmdWrData[31:16])};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      frameSr <= '0;
      rdSr    <= '0;
    end else begin
      if (strb.store)      cmdReg <= {cmdWrData[31:3], 1'b0, cmdWrData[1:0]};
      if (strb.commitRead) cmdReg[31:16] <= rdSr;
      if (strb.start)      frameSr <= {{PREAMBLE_LEN{1'b1}}, frameBody};
      else if (strb.shift) frameSr <= {frameSr[FRAME_LEN-2:0], 1'b0};
      if (strb.sample)     rdSr <= {rdSr[14:0], mdioIn};
    end
  end

  assign mdioOut  = frameSr[FRAME_LEN-1];
  assign regValue = {cmdReg[31:3], busy, cmdReg[1:0]};

  // R4: committing read data leaves the lower half alone
  p_low_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitRead |=> $stable(cmdReg[15:0]));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int MDC_HALF     = 2,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrEn,
  input  logic [31:0] cmdWrData,
  output logic [31:0] cmdRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  import mdio_pkg::*;

  mdioStrobe_t strb;
  logic        busy;

  mdio_ctrl #(.MDC_HALF(MDC_HALF), .PREAMBLE_LEN(PREAMBLE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .rdReq(cmdWrData[1]), .wrReq(cmdWrData[0]),
    .strb(strb), .mdc(mdc), .mdioOe(mdioOe), .busy(busy)
  );

  mdio_datapath #(.PREAMBLE_LEN(PREAMBLE_LEN)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWrData(cmdWrData),
    .mdioIn(mdioIn), .busy(busy), .mdioOut(mdioOut), .regValue(cmdRdData)
  );

  // R6: data only moves on a falling clock edge within a frame
  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdioOut));
  // R7: commands arriving while busy leave the lower register half unchanged
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrEn) |=> $stable(cmdRdData[15:3]));
endmodule

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
  localparam int HALF = 2;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [31:0] cmdWrData = '0;
  logic [31:0] cmdRdData;
  logic mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = !clk;

  mdio_cmd_master #(.MDC_HALF(HALF), .PREAMBLE_LEN(32)) u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .cmdRdData(cmdRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] phyAnswer(input logic [4:0] p, input logic [4:0] r);
    return 16'(p * 16'd1999 + r * 16'd7 + 16'h1234);
  endfunction

  task automatic issue(input logic [31:0] cmd);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = cmd;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  // full frame with a PHY model; expRead chooses opcode and answer
  task automatic runFrame(input logic [31:0] cmd, input bit expRead);
    logic [63:0] capBits, capOe, expFrame, expOe;
    logic [15:0] ans;
    logic [31:0] expReg;
    ans = phyAnswer(cmd[15:11], cmd[10:6]);
    issue(cmd);
    check(cmdRdData[2] == 1'b1, "R7 busy set", 64'(cmdRdData[2]), 64'd1);
    for (int i = 0; i < 64; i++) begin
      if (expRead && i == 47) mdioIn = 1'b0;
      if (expRead && i >= 48) mdioIn = ans[63 - i];
      @(posedge mdc);
      capBits[63 - i] = mdioOut;
      capOe[63 - i]   = mdioOe;
      @(negedge mdc);
    end
    mdioIn = 1'b1;
    @(negedge clk); @(negedge clk);
    expFrame = {32'hFFFF_FFFF, 2'b01, (expRead ? 2'b10 : 2'b01), cmd[15:11], cmd[10:6], 2'b10,
                (expRead ? 16'h0000 : cmd[31:16])};
    expOe = expRead ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    check(capOe == expOe, expRead ? "R4 line release" : "R3 line driven", capOe, expOe);
    check((capBits & expOe) == (expFrame & expOe), expRead ? "R1 R2 read frame" : "R1 R3 write frame",
          capBits & expOe, expFrame & expOe);
    expReg = expRead ? {ans, cmd[15:3], 1'b0, cmd[1:0]} : {cmd[31:3], 1'b0, cmd[1:0]};
    check(cmdRdData == expReg, expRead ? "R4 readback" : "R3 readback", 64'(cmdRdData), 64'(expReg));
  endtask

  initial begin
    realtime t0, t1;
    logic [31:0] c;
    logic [31:0] held;
    bit toggled;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(cmdRdData == 32'h0 && !mdc && !mdioOe, "R8 reset", {cmdRdData, 29'h0, mdc, mdioOe, 1'b0}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: no-op command stored, no frame
    c = 32'hBEEF_5A7C;
    issue(c);
    toggled = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mdc || mdioOe) toggled = 1'b1;
    end
    check(!toggled && cmdRdData[2] == 1'b0, "R5 no frame", 64'(toggled), 64'd0);
    check(cmdRdData == {c[31:3], 1'b0, c[1:0]}, "R5 stored", 64'(cmdRdData), 64'({c[31:3], 1'b0, c[1:0]}));

    // R6 period and R7 ignore while busy
    c = {16'hA5C3, 5'd3, 5'd9, 4'b0, 2'b01};
    issue(c);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check((t1 - t0) == 2 * HALF * 4.0, "R6 mdc period", 64'(int'(t1 - t0)), 64'(2 * HALF * 4));
    held = cmdRdData;
    issue({16'h1111, 5'd31, 5'd31, 4'b0, 2'b10});
    check(cmdRdData == held, "R7 ignored while busy", 64'(cmdRdData), 64'(held));
    while (cmdRdData[2]) @(negedge clk);
    check(cmdRdData == {c[31:3], 1'b0, c[1:0]}, "R7 register kept", 64'(cmdRdData), 64'({c[31:3], 1'b0, c[1:0]}));
    toggled = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mdc || cmdRdData[2]) toggled = 1'b1;
    end
    check(!toggled, "R7 no late frame", 64'(toggled), 64'd0);

    // sweep over all PHY addresses: write, then read (both bits on odd)
    for (int p = 0; p < 32; p++) begin
      logic [4:0] r;
      logic [15:0] d;
      r = 5'((p * 7 + 3) % 32);
      d = 16'(p * 16'd4099 + 16'h0F0F);
      runFrame({d, 5'(p), r, 3'b101, 1'b0, 2'b01}, 1'b0);
      runFrame({16'hFFFF - d, 5'(p), r, 3'b110, 1'b0, (p % 2 == 1) ? 2'b11 : 2'b10}, 1'b1);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule